// File: doc/BRIEF.md
# Key Matrix Change-Event Encoder

The block scans an 8x8 switch matrix. It pulls one column low at a time and reads eight row lines that idle high. It keeps a debounced copy of which keys are held. For every key whose held state changes, it produces a single 8-bit event code, for both presses and releases. Keys that do not change produce nothing. Codes wait in a small queue. An active-low interrupt line tells the host that at least one code is ready. The host reads the code at the head of the queue and removes it with a one-cycle pop strobe.

A scan works through the eight columns in turn. The block then makes one pass over all 64 key positions, one position per clock, in ascending key index, and emits the accepted changes during that pass. A press is blocked when it closes a 2x2 rectangle of switches that read closed, because the fourth corner of such a rectangle cannot be told apart from a real key. Any number of keys that do not form such a rectangle are tracked independently. When two successive scans find nothing closed, the block goes to sleep. In sleep it pulls every column low and stops scanning until some row falls.

Top module: `keymatrix_event_enc`

## Requirements
- R1: After reset, `col_n` is 8'h00 (asleep, all columns pulled low), `key_irq_n` is 1 and `overflow` is 0.
- R2: While awake, the block scans columns 0 to 7 in order. During the scan exactly one `col_n` bit is 0, held for SETTLE clocks before its rows are sampled. During the event pass `col_n` is 8'hFF. A single scan visits every column.
- R3: A key at column c, row r reads closed when `row_n[r]` is 0 while `col_n[c]` is 0. Its event code is {press, 1'b0, c[2:0], r[2:0]}, where bit 7 is 1 for a press and 0 for a release.
- R4: A key's new state is accepted only after two consecutive scans sample the same value. A closure seen in only one scan produces no event.
- R5: Each accepted press or release produces exactly one event. Keys whose state does not change produce none.
- R6: Changes accepted in the same scan are emitted in ascending key index c*8+r.
- R7: A new press is not reported if, together with three other keys that read closed, it forms the corners of a rectangle (two columns by two rows). A key blocked this way gives no release event when it opens.
- R8: Keys that form no such rectangle are each reported independently, whatever number are held at once.
- R9: When the last two scans both sampled no closed key, the block sleeps with `col_n` at 8'h00. It stays asleep while `row_n` is 8'hFF. The clock after any row reads 0, it restarts scanning at column 0 (`col_n` = 8'hFE).
- R10: Events pass through a DEPTH-entry (default 8) first-in first-out queue. `key_irq_n` is 0 exactly while the queue holds an event. `evt_code` shows the oldest event. A cycle with `evt_pop` high and the queue non-empty removes that event.
- R11: An event accepted while the queue is full is dropped, even if a pop happens in the same cycle. `overflow` then goes to 1 and stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_n | input | 8 | Row lines from the matrix, pulled up; 0 means a closed switch on a driven column |
| col_n | output | 8 | Column drives; 0 drives the column low, 1 releases it |
| key_irq_n | output | 1 | Low while an event waits in the queue |
| evt_code | output | 8 | Oldest queued event code |
| evt_pop | input | 1 | Removes the oldest event when high for one cycle |
| overflow | output | 1 | Sticky flag for a dropped event |

## Verification
The bench models the matrix as an undiode'd switch network. Phantom closures therefore appear on the rows exactly as real hardware would produce them. The ghost tests only pass if the rectangle check blocks both the real third key and its phantom. A design that checked only settled state would report one of them. The bench presses two keys during an event pass so that both enter the same scan, and it checks their order. A design that emitted in arrival order or highest-first would swap the codes. A closure shorter than one scan must produce nothing, which catches a design that accepts a single sample. The overflow test fills the queue, adds a ninth event, and then drains it. A design that overwrote the oldest entry, or cleared the flag on a pop, would give wrong codes or a zero flag.

// File: rtl/keymatrix_event_enc.sv
module keymatrix_event_enc #(
  parameter int SETTLE = 4,
  parameter int DEPTH  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] row_n,
  output logic [7:0] col_n,
  output logic       key_irq_n,
  output logic [7:0] evt_code,
  input  logic       evt_pop,
  output logic       overflow
);
  localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  typedef enum logic [1:0] {ST_SLEEP, ST_SCAN, ST_PASS} phase_t;

  phase_t        ph;
  logic [63:0]   raw, prv, stb;
  logic [2:0]    col;
  logic [CW-1:0] dly;
  logic [5:0]    idx;
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [NW-1:0] cnt;
  logic          ovf;
  logic          ghost;

  wire [2:0] kc = idx[5:3];
  wire [2:0] kr = idx[2:0];

  always_comb begin
    ghost = 1'b0;
    for (int c = 0; c < 8; c++) begin
      if (3'(c) != kc && raw[{3'(c), kr}] &&
          ((raw[{3'(c), 3'b000} +: 8] & raw[{kc, 3'b000} +: 8] & ~(8'b1 << kr)) != 8'b0))
        ghost = 1'b1;
    end
  end

  wire chg  = (raw[idx] == prv[idx]) && (raw[idx] != stb[idx]);
  wire take = (ph == ST_PASS) && chg && !(raw[idx] && ghost);
  wire full = (cnt == NW'(DEPTH));
  wire push = take && !full;
  wire popd = evt_pop && (cnt != '0);

  assign col_n     = (ph == ST_SLEEP) ? 8'h00 : (ph == ST_SCAN) ? ~(8'b1 << col) : 8'hFF;
  assign key_irq_n = (cnt == '0);
  assign evt_code  = mem[rp];
  assign overflow  = ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= ST_SLEEP;
      col <= '0;
      dly <= '0;
      idx <= '0;
      raw <= '0;
      prv <= '0;
      stb <= '0;
    end else begin
      case (ph)
        ST_SLEEP: begin
          col <= '0;
          dly <= '0;
          if (row_n != 8'hFF) ph <= ST_SCAN;
        end
        ST_SCAN: begin
          if (dly == CW'(SETTLE - 1)) begin
            raw[{col, 3'b000} +: 8] <= ~row_n;
            dly <= '0;
            col <= col + 3'd1;
            if (col == 3'd7) begin
              ph  <= ST_PASS;
              idx <= '0;
            end
          end else begin
            dly <= dly + CW'(1);
          end
        end
        default: begin
          if (take) stb[idx] <= raw[idx];
          idx <= idx + 6'd1;
          if (idx == 6'd63) begin
            prv <= raw;
            ph  <= (raw == '0 && prv == '0) ? ST_SLEEP : ST_SCAN;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (push) wp <= wp + AW'(1);
      if (popd) rp <= rp + AW'(1);
      cnt <= cnt + NW'(push) - NW'(popd);
      if (take && full) ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {raw[idx], 1'b0, idx};
  end
endmodule

// File: rtl/keymatrix_event_enc_chk.sv
module keymatrix_event_enc_chk #(
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [7:0]                 row_n,
  input logic [7:0]                 col_n,
  input logic                       key_irq_n,
  input logic [7:0]                 evt_code,
  input logic                       evt_pop,
  input logic                       overflow,
  input logic                       push,
  input logic [$clog2(DEPTH+1)-1:0] cnt
);
  assert_col_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(col_n) == 0 || $countones(col_n) == 7 || $countones(col_n) == 8));

  assert_code_fmt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !key_irq_n |-> !evt_code[6]);

  assert_sleep_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (col_n == 8'h00 && row_n == 8'hFF) |=> col_n == 8'h00);

  assert_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (col_n == 8'h00 && row_n != 8'hFF) |=> col_n == 8'hFE);

  assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pop && cnt == 1 && !push) |=> key_irq_n);

  assert_depth_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ($clog2(DEPTH+1))'(DEPTH));

  assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

bind keymatrix_event_enc keymatrix_event_enc_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_keymatrix_event_enc.sv
module tb_keymatrix_event_enc;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  row_n, col_n, evt_code;
  logic        key_irq_n, evt_pop, overflow;
  logic [63:0] keys;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [7:0] resolve(input logic [63:0] k, input logic [7:0] cn);
    logic [7:0] lc, lr;
    lc = ~cn;
    lr = 8'h00;
    for (int it = 0; it < 8; it++)
      for (int c = 0; c < 8; c++)
        for (int r = 0; r < 8; r++)
          if (k[c*8+r] && (lc[c] || lr[r])) begin
            lc[c] = 1'b1;
            lr[r] = 1'b1;
          end
    return ~lr;
  endfunction

  assign row_n = resolve(keys, col_n);

  keymatrix_event_enc dut (
    .clk(clk), .rst_n(rst_n), .row_n(row_n), .col_n(col_n),
    .key_irq_n(key_irq_n), .evt_code(evt_code), .evt_pop(evt_pop), .overflow(overflow)
  );

  // {key index, press, expected code}
  localparam logic [14:0] VEC [6] = '{
    {6'd27, 1'b1, 8'h9B},
    {6'd62, 1'b1, 8'hBE},
    {6'd27, 1'b0, 8'h1B},
    {6'd5,  1'b1, 8'h85},
    {6'd62, 1'b0, 8'h3E},
    {6'd5,  1'b0, 8'h05}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pop1();
    evt_pop = 1'b1;
    @(negedge clk);
    evt_pop = 1'b0;
  endtask

  task automatic expect_evt(input string req, input logic [7:0] exp);
    bit got = 1'b0;
    for (int i = 0; i < 3000 && !got; i++) begin
      @(negedge clk);
      if (!key_irq_n) got = 1'b1;
    end
    if (!got) chk(1'b0, req, 64'h1, 64'h0);
    else begin
      chk(evt_code == exp, req, evt_code, exp);
      pop1();
    end
  endtask

  task automatic quiet(input string req, input int n);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!key_irq_n) seen = 1'b1;
    end
    chk(!seen, req, seen, 0);
  endtask

  task automatic wait_pass();
    for (int i = 0; i < 3000 && col_n != 8'hFF; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(4);
    rst_n = 1'b1;
    cyc(1);
  endtask

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    keys = '0;
    evt_pop = 1'b0;
    do_reset();

    chk(col_n == 8'h00, "R1 col_n", col_n, 8'h00);
    chk(key_irq_n == 1'b1, "R1 key_irq_n", key_irq_n, 1);
    chk(overflow == 1'b0, "R1 overflow", overflow, 0);

    for (int v = 0; v < 6; v++) begin
      keys[VEC[v][14:9]] = VEC[v][8];
      expect_evt("R3 R5 table", VEC[v][7:0]);
    end

    begin
      bit stay = 1'b1;
      cyc(600);
      for (int i = 0; i < 50; i++) begin
        @(negedge clk);
        if (col_n != 8'h00) stay = 1'b0;
      end
      chk(stay, "R9 sleep after release", {7'd0, stay}, 1);
    end

    keys[0] = 1'b1;
    expect_evt("R3 wake press", 8'h80);
    begin
      bit ok = 1'b1;
      logic [7:0] seen = 8'h00;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if ($countones(col_n) == 7) seen |= ~col_n;
        else if (col_n != 8'hFF) ok = 1'b0;
      end
      chk(ok, "R2 single column drive", col_n, 8'hFE);
      chk(seen == 8'hFF, "R2 every column visited", seen, 8'hFF);
    end

    wait_pass();
    keys[18] = 1'b1;
    keys[9]  = 1'b1;
    expect_evt("R6 ascending first", 8'h89);
    expect_evt("R6 ascending second", 8'h92);
    wait_pass();
    keys[18] = 1'b0;
    keys[9]  = 1'b0;
    expect_evt("R6 release first", 8'h09);
    expect_evt("R6 release second", 8'h12);

    keys[1] = 1'b1;
    expect_evt("R8 second key in column", 8'h81);
    keys[9] = 1'b1;
    quiet("R7 rectangle press blocked", 1000);
    keys[9] = 1'b0;
    quiet("R7 blocked key no release", 800);
    keys[63] = 1'b1;
    expect_evt("R8 third independent key", 8'hBF);
    keys[1] = 1'b0;
    expect_evt("R8 release while others held", 8'h01);
    keys[0] = 1'b0;
    expect_evt("R8 release key 0", 8'h00);
    keys[63] = 1'b0;
    expect_evt("R8 release key 63", 8'h3F);
    cyc(600);
    chk(col_n == 8'h00, "R9 asleep before glitch", col_n, 8'h00);

    keys[0] = 1'b1;
    cyc(20);
    keys[0] = 1'b0;
    quiet("R4 single-scan glitch ignored", 1500);
    chk(col_n == 8'h00, "R9 back asleep after glitch", col_n, 8'h00);

    begin
      int seq [9] = '{0, 8, 16, 24, 33, 34, 35, 36, 37};
      logic [7:0] exp [8] = '{8'h80, 8'h88, 8'h90, 8'h98, 8'hA1, 8'hA2, 8'hA3, 8'hA4};
      for (int k = 0; k < 8; k++) begin
        keys[seq[k]] = 1'b1;
        cyc(600);
      end
      chk(key_irq_n == 1'b0, "R10 irq low while queued", key_irq_n, 0);
      chk(overflow == 1'b0, "R11 no overflow at depth", overflow, 0);
      keys[seq[8]] = 1'b1;
      cyc(600);
      chk(overflow == 1'b1, "R11 overflow on ninth", overflow, 1);
      for (int k = 0; k < 8; k++) begin
        chk(evt_code == exp[k], "R10 queue order", evt_code, exp[k]);
        pop1();
      end
      chk(key_irq_n == 1'b1, "R11 newest dropped, queue empty", key_irq_n, 1);
      chk(overflow == 1'b1, "R11 overflow sticky after drain", overflow, 1);
    end

    keys = '0;
    cyc(10);
    do_reset();
    chk(overflow == 1'b0, "R1 R11 reset clears overflow", overflow, 0);
    chk(key_irq_n == 1'b1, "R1 reset empties queue", key_irq_n, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule